// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes configuration words for a dual-loop frequency synthesizer over a three-wire serial link: a serial clock, a data line and a latch-enable strobe. All three lines are asynchronous to the system clock. They pass through a two-stage synchronizer, and their edges are found in the system clock domain. Each synchronized rising edge of the serial clock shifts one data bit, most significant first, into an 18-bit shift register. A rising edge of the latch-enable strobe copies the register into one of four latches. The two bits shifted in last choose which latch.

The latches hold the reference divide values and feedback divide values of the main loop and the auxiliary loop, a 4-bit charge-pump control word and a 4-bit output-select word. The feedback values are also split into swallow (A) and binary (B) counter fields. A reference value below the legal minimum is refused, the latch keeps its old contents, and a sticky error flag is set. The output-select word drives a multiplexer that routes one of the loop status signals, or a constant level, to a single output pin. The serial interface has no power-down gating, so frames are taken at any time.

Top module: `ser_cfg_loader`

## Requirements
- R1: Each synchronized rising edge of `sclk_i` shifts the current `sdata_i` value into bit 0 of an 18-bit shift register, and older bits move up one place. The first bit sent therefore ends in bit 17.
- R2: A synchronized rising edge of `sle_i` copies the shift register into the latch chosen by bits 1:0: 00 aux reference, 01 aux feedback, 10 main reference, 11 main feedback. The other latches keep their values, and nothing changes without such an edge.
- R3: In reference frames, bits 13:2 carry the 12-bit divide value. A value of 0 or 1 is refused: the whole frame is dropped, the latch keeps its old contents, and `r_err_o` rises and stays high until reset. A value of 2 is accepted.
- R4: An accepted aux-reference frame loads bits 17:14 into `out_sel_o`.
- R5: An accepted main-reference frame loads bit 17 to `aux_cp_gain_o`, bit 16 to `main_cp_gain_o`, bit 15 to `aux_pd_pol_o` and bit 14 to `main_pd_pol_o`.
- R6: Feedback frames load bits 17:2 as the 16-bit value. The low 4 bits form `aux_a_o` and the upper 12 bits form `aux_b_o`. The main value splits into a low 5-bit `main_a_o` and an upper 11-bit `main_b_o`.
- R7: `mux_o` follows `out_sel_o` without delay: 0 gives low, 1 gives high, 2 main lock, 3 aux lock, 4 main AND aux lock, 5 main reference output, 6 aux reference output, 7 main feedback output, 8 aux feedback output, and 9 to 15 give low.
- R8: After reset both reference values are 2, both feedback values are 0, and the charge-pump bits, `out_sel_o` and `r_err_o` are 0.
- R9: A latch output changes on the third rising system clock edge. The count starts at, and includes, the first edge that samples `sle_i` high.
- R10: The number of serial clocks before a strobe is not checked. Only the 18 bits shifted in last are used, whether that is more or fewer than 18 bits from the newest frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| sle_i | input | 1 | Latch-enable strobe |
| main_lock_i | input | 1 | Main loop lock status |
| aux_lock_i | input | 1 | Aux loop lock status |
| main_ref_i | input | 1 | Main reference counter output |
| aux_ref_i | input | 1 | Aux reference counter output |
| main_fb_i | input | 1 | Main feedback counter output |
| aux_fb_i | input | 1 | Aux feedback counter output |
| aux_r_o | output | 12 | Aux reference divide value |
| main_r_o | output | 12 | Main reference divide value |
| aux_n_o | output | 16 | Aux feedback divide value |
| main_n_o | output | 16 | Main feedback divide value |
| aux_a_o | output | 4 | Aux swallow count |
| aux_b_o | output | 12 | Aux binary count |
| main_a_o | output | 5 | Main swallow count |
| main_b_o | output | 11 | Main binary count |
| aux_cp_gain_o | output | 1 | Aux charge-pump high gain |
| main_cp_gain_o | output | 1 | Main charge-pump high gain |
| aux_pd_pol_o | output | 1 | Aux detector polarity positive |
| main_pd_pol_o | output | 1 | Main detector polarity positive |
| out_sel_o | output | 4 | Output-select word |
| r_err_o | output | 1 | Sticky illegal reference value flag |
| mux_o | output | 1 | Multiplexed status output |

## Verification
A wrong bit in the shift register shows up only at the next strobe. It then appears as a wrong latch value, a wrong latch chosen, or a wrong error flag, on the third clock edge after the strobe is sampled. A corrupted latch or select word appears at once on `mux_o` or on the field outputs, and stays wrong until the next frame for that latch. Off-by-one faults in the synchronizer depth or the edge detection move the update one clock early or late, and the every-cycle comparison against the reference model reports this in the first cycle it happens.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int FRAME_W = 18;

  typedef enum logic [1:0] {
    ADR_AUX_R  = 2'b00,
    ADR_AUX_N  = 2'b01,
    ADR_MAIN_R = 2'b10,
    ADR_MAIN_N = 2'b11
  } adr_e;

  typedef struct packed {
    logic aux_gain;
    logic main_gain;
    logic aux_pol;
    logic main_pol;
  } cp_t;

  typedef enum logic [3:0] {
    SEL_LO    = 4'd0,
    SEL_HI    = 4'd1,
    SEL_MLOCK = 4'd2,
    SEL_ALOCK = 4'd3,
    SEL_BOTH  = 4'd4,
    SEL_MREF  = 4'd5,
    SEL_AREF  = 4'd6,
    SEL_MFB   = 4'd7,
    SEL_AFB   = 4'd8
  } osel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;

  // an edge pulse never lasts two cycles
  p_single_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] sh_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[W-2:0], din_i};
  end

  assign sh_o = sh_q;

  p_shift_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (sh_o[0] == $past(din_i)) && (sh_o[W-1:1] == $past(sh_o[W-2:0])));
  p_shift_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sh_o));
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_pkg::*;
#(
  parameter int R_W   = 12,
  parameter int N_W   = 16,
  parameter int R_MIN = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [R_W-1:0]     aux_r_o,
  output logic [R_W-1:0]     main_r_o,
  output logic [N_W-1:0]     aux_n_o,
  output logic [N_W-1:0]     main_n_o,
  output cp_t                cp_o,
  output logic [3:0]         sel_o,
  output logic               err_o
);
  localparam int R_LO   = 2;
  localparam int R_HI   = R_LO + R_W - 1;
  localparam int TOP_LO = R_HI + 1;

  adr_e           adr;
  logic [R_W-1:0] r_val;
  logic [N_W-1:0] n_val;
  logic [3:0]     top_val;
  logic           r_ok;

  assign adr     = adr_e'(frame_i[1:0]);
  assign r_val   = frame_i[R_HI:R_LO];
  assign n_val   = frame_i[N_W+1:2];
  assign top_val = frame_i[FRAME_W-1:TOP_LO];
  assign r_ok    = (r_val >= R_W'(R_MIN));

  logic [R_W-1:0] aux_r_q, main_r_q;
  logic [N_W-1:0] aux_n_q, main_n_q;
  cp_t            cp_q;
  logic [3:0]     sel_q;
  logic           err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_r_q  <= R_W'(R_MIN);
      main_r_q <= R_W'(R_MIN);
      aux_n_q  <= '0;
      main_n_q <= '0;
      cp_q     <= '0;
      sel_q    <= '0;
      err_q    <= 1'b0;
    end else if (load_i) begin
      unique case (adr)
        ADR_AUX_R: begin
          if (r_ok) begin
            aux_r_q <= r_val;
            sel_q   <= top_val;
          end else begin
            err_q <= 1'b1;
          end
        end
        ADR_MAIN_R: begin
          if (r_ok) begin
            main_r_q <= r_val;
            cp_q     <= cp_t'(top_val);
          end else begin
            err_q <= 1'b1;
          end
        end
        ADR_AUX_N:  aux_n_q  <= n_val;
        ADR_MAIN_N: main_n_q <= n_val;
        default: ;
      endcase
    end
  end

  assign aux_r_o  = aux_r_q;
  assign main_r_o = main_r_q;
  assign aux_n_o  = aux_n_q;
  assign main_n_o = main_n_q;
  assign cp_o     = cp_q;
  assign sel_o    = sel_q;
  assign err_o    = err_q;

  p_r_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_r_o >= R_W'(R_MIN)) && (main_r_o >= R_W'(R_MIN)));
  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(aux_r_o) && $stable(main_r_o) && $stable(aux_n_o)
                && $stable(main_n_o) && $stable(cp_o) && $stable(sel_o));
  p_n_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && frame_i[0]) |=> $stable(aux_r_o) && $stable(main_r_o) && $stable(cp_o));
  p_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !frame_i[0] && (frame_i[R_HI:R_LO] < R_W'(R_MIN)))
      |=> err_o && $stable(aux_r_o) && $stable(main_r_o));
endmodule

// File: rtl/cfg_outmux.sv
module cfg_outmux
  import cfg_pkg::*;
(
  input  logic [3:0] sel_i,
  input  logic       main_lock_i,
  input  logic       aux_lock_i,
  input  logic       main_ref_i,
  input  logic       aux_ref_i,
  input  logic       main_fb_i,
  input  logic       aux_fb_i,
  output logic       out_o
);
  always_comb begin
    unique case (osel_e'(sel_i))
      SEL_HI:    out_o = 1'b1;
      SEL_MLOCK: out_o = main_lock_i;
      SEL_ALOCK: out_o = aux_lock_i;
      SEL_BOTH:  out_o = main_lock_i & aux_lock_i;
      SEL_MREF:  out_o = main_ref_i;
      SEL_AREF:  out_o = aux_ref_i;
      SEL_MFB:   out_o = main_fb_i;
      SEL_AFB:   out_o = aux_fb_i;
      default:   out_o = 1'b0;
    endcase
  end

  a_both_r7: assert final (!(osel_e'(sel_i) == SEL_BOTH) || (out_o == (main_lock_i && aux_lock_i)));
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int R_W         = 12,
  parameter int N_W         = 16,
  parameter int R_MIN       = 2,
  parameter int AUX_A_W     = 4,
  parameter int MAIN_A_W    = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  sdata_i,
  input  logic                  sle_i,
  input  logic                  main_lock_i,
  input  logic                  aux_lock_i,
  input  logic                  main_ref_i,
  input  logic                  aux_ref_i,
  input  logic                  main_fb_i,
  input  logic                  aux_fb_i,
  output logic [R_W-1:0]        aux_r_o,
  output logic [R_W-1:0]        main_r_o,
  output logic [N_W-1:0]        aux_n_o,
  output logic [N_W-1:0]        main_n_o,
  output logic [AUX_A_W-1:0]    aux_a_o,
  output logic [N_W-AUX_A_W-1:0]  aux_b_o,
  output logic [MAIN_A_W-1:0]   main_a_o,
  output logic [N_W-MAIN_A_W-1:0] main_b_o,
  output logic                  aux_cp_gain_o,
  output logic                  main_cp_gain_o,
  output logic                  aux_pd_pol_o,
  output logic                  main_pd_pol_o,
  output logic [3:0]            out_sel_o,
  output logic                  r_err_o,
  output logic                  mux_o
);
  // bit order on the synchronizer: {strobe, data, shift clock}
  localparam int B_CLK = 0;
  localparam int B_DAT = 1;
  localparam int B_LE  = 2;

  logic [2:0]         sync_w, rise_w;
  logic [FRAME_W-1:0] sh_w;
  cp_t                cp_w;
  logic               unused_sync;

  cfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sle_i, sdata_i, sclk_i}),
    .sync_o  (sync_w),
    .rise_o  (rise_w)
  );

  assign unused_sync = &{1'b0, sync_w[B_CLK], sync_w[B_LE], rise_w[B_DAT]};

  cfg_shift #(.W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rise_w[B_CLK]),
    .din_i  (sync_w[B_DAT]),
    .sh_o   (sh_w)
  );

  cfg_bank #(.R_W(R_W), .N_W(N_W), .R_MIN(R_MIN)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rise_w[B_LE]),
    .frame_i  (sh_w),
    .aux_r_o  (aux_r_o),
    .main_r_o (main_r_o),
    .aux_n_o  (aux_n_o),
    .main_n_o (main_n_o),
    .cp_o     (cp_w),
    .sel_o    (out_sel_o),
    .err_o    (r_err_o)
  );

  cfg_outmux u_mux (
    .sel_i       (out_sel_o),
    .main_lock_i (main_lock_i),
    .aux_lock_i  (aux_lock_i),
    .main_ref_i  (main_ref_i),
    .aux_ref_i   (aux_ref_i),
    .main_fb_i   (main_fb_i),
    .aux_fb_i    (aux_fb_i),
    .out_o       (mux_o)
  );

  assign aux_cp_gain_o  = cp_w.aux_gain;
  assign main_cp_gain_o = cp_w.main_gain;
  assign aux_pd_pol_o   = cp_w.aux_pol;
  assign main_pd_pol_o  = cp_w.main_pol;

  assign aux_a_o  = aux_n_o[AUX_A_W-1:0];
  assign aux_b_o  = aux_n_o[N_W-1:AUX_A_W];
  assign main_a_o = main_n_o[MAIN_A_W-1:0];
  assign main_b_o = main_n_o[N_W-1:MAIN_A_W];

  p_main_n_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_w[B_LE] && sh_w[1:0] == ADR_MAIN_N) |=> main_n_o == $past(sh_w[N_W+1:2]));
  p_aux_n_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_w[B_LE] && sh_w[1:0] == ADR_AUX_N) |=> aux_n_o == $past(sh_w[N_W+1:2]));
endmodule

// File: tb/sim_ser_cfg_loader.sv
module sim_ser_cfg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sclk = 0, sdata = 0, sle = 0;
  logic ml = 0, al = 0, mref = 0, aref = 0, mfb = 0, afb = 0;
  logic [11:0] aux_r, main_r;
  logic [15:0] aux_n, main_n;
  logic [3:0]  aux_a;
  logic [11:0] aux_b;
  logic [4:0]  main_a;
  logic [10:0] main_b;
  logic ag, mg, ap, mp, err, mux;
  logic [3:0] sel;

  ser_cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .main_lock_i(ml), .aux_lock_i(al), .main_ref_i(mref), .aux_ref_i(aref),
    .main_fb_i(mfb), .aux_fb_i(afb),
    .aux_r_o(aux_r), .main_r_o(main_r), .aux_n_o(aux_n), .main_n_o(main_n),
    .aux_a_o(aux_a), .aux_b_o(aux_b), .main_a_o(main_a), .main_b_o(main_b),
    .aux_cp_gain_o(ag), .main_cp_gain_o(mg), .aux_pd_pol_o(ap), .main_pd_pol_o(mp),
    .out_sel_o(sel), .r_err_o(err), .mux_o(mux)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [17:0] m_sh;
  logic [11:0] m_auxr, m_mainr;
  logic [15:0] m_auxn, m_mainn;
  logic [3:0]  m_cp, m_sel;
  logic        m_err;
  logic [2:0]  h1, h2, h3;  // sampled {le,data,clk}, 1..3 edges back

  function automatic logic mux_ref(input logic [3:0] s);
    case (s)
      4'd1: return 1'b1;
      4'd2: return ml;
      4'd3: return al;
      4'd4: return ml & al;
      4'd5: return mref;
      4'd6: return aref;
      4'd7: return mfb;
      4'd8: return afb;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh = '0; m_auxr = 12'd2; m_mainr = 12'd2; m_auxn = '0; m_mainn = '0;
      m_cp = '0; m_sel = '0; m_err = 1'b0; h1 = '0; h2 = '0; h3 = '0;
    end else begin
      if (h2[2] && !h3[2]) begin
        case (m_sh[1:0])
          2'b00: if (m_sh[13:2] < 2) m_err = 1'b1;
                 else begin m_auxr = m_sh[13:2]; m_sel = m_sh[17:14]; end
          2'b10: if (m_sh[13:2] < 2) m_err = 1'b1;
                 else begin m_mainr = m_sh[13:2]; m_cp = m_sh[17:14]; end
          2'b01: m_auxn = m_sh[17:2];
          default: m_mainn = m_sh[17:2];
        endcase
      end
      if (h2[0] && !h3[0]) m_sh = {m_sh[16:0], h2[1]};
      h3 = h2; h2 = h1; h1 = {sle, sdata, sclk};
    end
  end

  int cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk({aux_r, main_r, aux_n, main_n} == {m_auxr, m_mainr, m_auxn, m_mainn},
          "R2 model latches", {aux_r, main_r, aux_n, main_n}, {m_auxr, m_mainr, m_auxn, m_mainn});
      chk(err == m_err, "R3 model err", err, m_err);
      chk(sel == m_sel, "R4 model sel", sel, m_sel);
      chk({ag, mg, ap, mp} == m_cp, "R5 model cp", {ag, mg, ap, mp}, m_cp);
      chk({aux_b, aux_a, main_b, main_a} == {m_auxn, m_mainn}, "R6 model split",
          {aux_b, aux_a, main_b, main_a}, {m_auxn, m_mainn});
      chk(mux == mux_ref(sel), "R7 model mux", mux, mux_ref(sel));
    end
    cnt++;
    mref = cnt[0]; aref = cnt[1]; mfb = cnt[2] ^ cnt[5];
    ml = cnt[3]; al = cnt[4]; afb = cnt[1] ^ cnt[3];
  end

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 0;
    repeat (2) @(negedge clk);
    sclk = 1;
    repeat (2) @(negedge clk);
    sclk = 0;
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic strobe();
    @(negedge clk); sle = 1;
    repeat (3) @(negedge clk);
    sle = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input logic [17:0] f);
    shift_bits({14'd0, f}, 18);
    strobe();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk({aux_r, main_r} == {12'd2, 12'd2}, "R8 reset R", {aux_r, main_r}, {12'd2, 12'd2});
    chk({aux_n, main_n} == 32'd0, "R8 reset N", {aux_n, main_n}, 0);
    chk({ag, mg, ap, mp, sel, err, mux} == 0, "R8 reset ctl", {ag, mg, ap, mp, sel, err, mux}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 R4 aux reference frame
    frame({4'd2, 12'd100, 2'b00});
    chk(aux_r == 12'd100, "R2 aux_r", aux_r, 100);
    chk(sel == 4'd2, "R4 sel", sel, 2);
    chk(main_r == 12'd2, "R2 main_r untouched", main_r, 2);

    // R5 main reference frame
    frame({4'b1010, 12'd4095, 2'b10});
    chk(main_r == 12'd4095, "R2 main_r", main_r, 4095);
    chk({ag, mg, ap, mp} == 4'b1010, "R5 cp bits", {ag, mg, ap, mp}, 4'b1010);
    chk(aux_r == 12'd100, "R2 aux_r untouched", aux_r, 100);

    // R3 illegal value refused, sticky error
    chk(err == 1'b0, "R3 err before", err, 0);
    frame({4'b0101, 12'd1, 2'b10});
    chk(main_r == 12'd4095, "R3 main_r kept", main_r, 4095);
    chk({ag, mg, ap, mp} == 4'b1010, "R3 cp kept", {ag, mg, ap, mp}, 4'b1010);
    chk(err == 1'b1, "R3 err set", err, 1);
    frame({4'd7, 12'd0, 2'b00});
    chk(aux_r == 12'd100 && sel == 4'd2, "R3 aux kept", {sel, aux_r}, {4'd2, 12'd100});
    frame({4'd3, 12'd2, 2'b00});
    chk(aux_r == 12'd2, "R3 boundary 2 accepted", aux_r, 2);
    chk(err == 1'b1, "R3 err sticky", err, 1);

    // R6 feedback frames
    frame({16'hABCD, 2'b01});
    chk(aux_n == 16'hABCD, "R6 aux_n", aux_n, 16'hABCD);
    chk(aux_a == 4'hD && aux_b == 12'hABC, "R6 aux split", {aux_b, aux_a}, {12'hABC, 4'hD});
    frame({16'h1234, 2'b11});
    chk(main_a == 5'h14 && main_b == 11'h091, "R6 main split", {main_b, main_a}, {11'h091, 5'h14});
    chk(aux_n == 16'hABCD, "R2 aux_n untouched", aux_n, 16'hABCD);

    // R10 fewer bits: 10 new bits after a main feedback frame
    shift_bits({22'd0, 8'hA5, 2'b01}, 10);
    strobe();
    chk(aux_n == 16'hD3A5, "R10 short frame", aux_n, 16'hD3A5);
    // R10 more bits: 4 junk bits ahead of a full frame
    shift_bits({10'd0, 4'hF, 16'h0F0F, 2'b01}, 22);
    strobe();
    chk(aux_n == 16'h0F0F, "R10 long frame", aux_n, 16'h0F0F);

    // R9 latency of a strobe; R1 MSB first
    shift_bits({14'd0, 16'h8001, 2'b11}, 18);
    @(negedge clk); sle = 1;
    @(negedge clk);
    @(negedge clk);
    chk(main_n == 16'h1234, "R9 not yet", main_n, 16'h1234);
    @(negedge clk);
    chk(main_n == 16'h8001, "R9 R1 updated on third edge", main_n, 16'h8001);
    sle = 0;
    repeat (4) @(negedge clk);

    // R2 data toggling without clock or strobe changes nothing
    for (int i = 0; i < 8; i++) begin @(negedge clk); sdata = ~sdata; end
    strobe();
    chk(main_n == 16'h8001, "R2 repeat strobe same frame", main_n, 16'h8001);

    // R7 every select code
    for (int s = 0; s < 16; s++) begin
      frame({s[3:0], 12'd50, 2'b00});
      chk(sel == s[3:0], "R4 sel code", sel, s);
      repeat (8) begin
        @(negedge clk); #1;
        chk(mux == mux_ref(s[3:0]), "R7 mux code", mux, mux_ref(s[3:0]));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule